// File: doc/BRIEF.md
# Multi-Channel Down-Count Timer Bank

This block is a bank of independent down-counting timers on an APB slave port. Each channel holds a programmable load value and a live count. The count drops by one on every cycle in which the shared `tick_en` input is high and the channel is running. When the count is at zero on a tick, the channel reloads and latches a pending interrupt. The reload value depends on the channel's mode. Periodic mode reloads the programmed load value. Free-running mode reloads all ones, which gives the longest timeout before the next event, so software can use it to emulate a one-shot timer. Each channel drives its own interrupt line. A shared register area gives software a view of all channels at once and holds a fixed version word.

Software stops a channel by clearing its enable bit, writes the load value, and then sets enable again, which starts the count from the load value. A read of a channel's interrupt-clear register acknowledges that channel's interrupt. A counter can also serve as a monotonic time base: the live count is readable at any time, and the raw status shows a rollover even when the interrupt is masked.

There is no data stream here, so there is no valid/ready pair. The APB handshake is the only flow control. `pready` is always high: every access completes in its access phase, and the slave never applies back-pressure.

Top module: `apbtmr_top`

## Requirements
- R1: Channel n's registers start at byte address n×0x14. The offsets are: 0x00 load value (read/write), 0x04 live count (read-only), 0x08 control (read/write), 0x0C interrupt clear (read-only), 0x10 channel status (bit 0 = pending AND NOT mask). The shared area starts at 0xA0.
- R2: A running channel's count decrements by one on each clock cycle in which `tick_en` is 1 and the count is not zero. When enable is 0 the count holds its value, and clearing enable keeps the value reached.
- R3: Control bit 0 is enable. A write that takes enable from 0 to 1 copies the load value into the count in that same cycle.
- R4: Control bit 1 is mode. When mode is 1 (periodic) and the count is 0 on a tick, the count reloads with the load value.
- R5: When mode is 0 (free-running) and the count is 0 on a tick, the count reloads 0xFFFF_FFFF and then continues counting down from it.
- R6: A write to the load value while the channel is enabled is ignored.
- R7: The count being 0 on a tick sets the channel's pending flag. A read of offset 0x0C returns 0 and clears the pending flag.
- R8: Control bit 2 is mask. `irq_o[n]` is pending AND NOT mask AND enable. The pending flag survives a change of mask or enable.
- R9: The register at 0xA0 holds the raw status, with bit n = pending of channel n whatever the mask. The register at 0xA4 holds the masked status, with bit n = pending AND NOT mask. Reading either one changes nothing.
- R10: The register at 0xA8 returns the constant VERSION. Writes to 0xA0, 0xA4 and 0xA8 are ignored.
- R11: `pready` is always 1. A read of an unmapped or unaligned address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bus and the counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count enable shared by all channels |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | APB ready, tied high |
| irq_o | output | NUM_CH | Interrupt line of each channel |

## Verification
The hardest state to reach from the ports is a rollover while the interrupt is masked. The pending flag must then be visible in the raw status but absent from the masked status and from `irq_o`, and it must stay pending after the mask is lifted. The stimulus holds `tick_en` low during every bus access, so each count is known exactly. It programs a free-running channel with a small load value and its mask bit set, and then issues exactly enough tick pulses to pass through zero. It then reads both status words, unmasks the channel and disables it, checking `irq_o` after each step. Meanwhile a second, periodic channel keeps counting, and its expected count is followed tick by tick.

// File: rtl/apbtmr_pkg.sv
package apbtmr_pkg;

  localparam int OFF_LOAD = 'h00;
  localparam int OFF_CUR  = 'h04;
  localparam int OFF_CTRL = 'h08;
  localparam int OFF_CLR  = 'h0C;
  localparam int OFF_STAT = 'h10;

  localparam int GOFF_RAW = 'h00;
  localparam int GOFF_MSK = 'h04;
  localparam int GOFF_VER = 'h08;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctrl_t;

endpackage

// File: rtl/apbtmr_decode.sv
module apbtmr_decode #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8,
  parameter int STRIDE = 'h14,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [NUM_CH-1:0] wr_load,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] rd_clr,
  output logic              hit_ch,
  output logic              hit_glob,
  output logic [CH_W-1:0]   ch_idx,
  output logic [ADDR_W-1:0] reg_off
);
  import apbtmr_pkg::*;

  localparam int CH_SPAN   = NUM_CH * STRIDE;
  localparam int GLOB_SPAN = 'h0C;
  localparam logic [ADDR_W-1:0] STRIDE_V = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] SPAN_V   = ADDR_W'(CH_SPAN);
  localparam logic [ADDR_W-1:0] GEND_V   = ADDR_W'(CH_SPAN + GLOB_SPAN);

  logic              aligned;
  logic              acc_wr;
  logic              acc_rd;
  logic [ADDR_W-1:0] quot;
  logic [ADDR_W-1:0] rem;

  assign aligned  = (paddr[1:0] == 2'b00);
  assign acc_wr   = psel && penable && pwrite;
  assign acc_rd   = psel && penable && !pwrite;
  assign quot     = paddr / STRIDE_V;
  assign rem      = paddr % STRIDE_V;
  assign hit_ch   = aligned && (paddr < SPAN_V);
  assign hit_glob = aligned && (paddr >= SPAN_V) && (paddr < GEND_V);
  assign ch_idx   = quot[CH_W-1:0];
  assign reg_off  = hit_ch ? rem : (paddr - SPAN_V);

  always_comb begin
    wr_load = '0;
    wr_ctrl = '0;
    rd_clr  = '0;
    if (hit_ch) begin
      wr_load[ch_idx] = acc_wr && (rem == ADDR_W'(OFF_LOAD));
      wr_ctrl[ch_idx] = acc_wr && (rem == ADDR_W'(OFF_CTRL));
      rd_clr[ch_idx]  = acc_rd && (rem == ADDR_W'(OFF_CLR));
    end
  end

  // R1
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_load, wr_ctrl, rd_clr}));

endmodule

// File: rtl/apbtmr_chan.sv
module apbtmr_chan #(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_en,
  input  logic               wr_load,
  input  logic               wr_ctrl,
  input  logic               rd_clr,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   load_q,
  output logic [CNT_W-1:0]   count_q,
  output apbtmr_pkg::ctrl_t  ctrl_q,
  output logic               pending_q,
  output logic               irq
);
  import apbtmr_pkg::*;

  logic  start;
  logic  at_zero;
  logic  expire;
  ctrl_t ctrl_d;

  assign ctrl_d  = ctrl_t'(wdata[CTRL_W-1:0]);
  assign start   = wr_ctrl && ctrl_d.en && !ctrl_q.en;
  assign at_zero = (count_q == '0);
  assign expire  = ctrl_q.en && tick_en && at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
    end else if (wr_load && !ctrl_q.en) begin
      load_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (start) begin
      count_q <= load_q;
    end else if (ctrl_q.en && tick_en) begin
      if (at_zero) begin
        count_q <= ctrl_q.periodic ? load_q : '1;
      end else begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else if (expire) begin
      pending_q <= 1'b1;
    end else if (rd_clr) begin
      pending_q <= 1'b0;
    end
  end

  assign irq = pending_q && !ctrl_q.mask && ctrl_q.en;

  // R2
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && tick_en && !at_zero && !start) |=> (count_q == $past(count_q) - 1'b1));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !start) |=> $stable(count_q));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !start) |=> (pending_q && count_q == ($past(ctrl_q.periodic) ? $past(load_q) : '1)));

  // R6
  load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.en && wr_load) |=> $stable(load_q));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !expire) |=> !pending_q);

endmodule

// File: rtl/apbtmr_top.sv
module apbtmr_top #(
  parameter int          NUM_CH  = 8,
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 8,
  parameter int          STRIDE  = 'h14,
  parameter logic [31:0] VERSION = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic [NUM_CH-1:0] irq_o
);
  import apbtmr_pkg::*;

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0] wr_load;
  logic [NUM_CH-1:0] wr_ctrl;
  logic [NUM_CH-1:0] rd_clr;
  logic              hit_ch;
  logic              hit_glob;
  logic [CH_W-1:0]   ch_idx;
  logic [ADDR_W-1:0] reg_off;

  logic [CNT_W-1:0]  load_a  [NUM_CH];
  logic [CNT_W-1:0]  count_a [NUM_CH];
  ctrl_t             ctrl_a  [NUM_CH];
  logic [NUM_CH-1:0] pend_v;
  logic [NUM_CH-1:0] mask_v;

  apbtmr_decode #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .STRIDE (STRIDE)
  ) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .wr_load  (wr_load),
    .wr_ctrl  (wr_ctrl),
    .rd_clr   (rd_clr),
    .hit_ch   (hit_ch),
    .hit_glob (hit_glob),
    .ch_idx   (ch_idx),
    .reg_off  (reg_off)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    apbtmr_chan #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .wr_load   (wr_load[g]),
      .wr_ctrl   (wr_ctrl[g]),
      .rd_clr    (rd_clr[g]),
      .wdata     (pwdata[CNT_W-1:0]),
      .load_q    (load_a[g]),
      .count_q   (count_a[g]),
      .ctrl_q    (ctrl_a[g]),
      .pending_q (pend_v[g]),
      .irq       (irq_o[g])
    );
    assign mask_v[g] = ctrl_a[g].mask;
  end

  assign pready = 1'b1;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ch) begin
        case (reg_off)
          ADDR_W'(OFF_LOAD): prdata = 32'(load_a[ch_idx]);
          ADDR_W'(OFF_CUR):  prdata = 32'(count_a[ch_idx]);
          ADDR_W'(OFF_CTRL): prdata = 32'(ctrl_a[ch_idx]);
          ADDR_W'(OFF_STAT): prdata = 32'(pend_v[ch_idx] && !mask_v[ch_idx]);
          default:           prdata = '0;
        endcase
      end else if (hit_glob) begin
        case (reg_off)
          ADDR_W'(GOFF_RAW): prdata = 32'(pend_v);
          ADDR_W'(GOFF_MSK): prdata = 32'(pend_v & ~mask_v);
          ADDR_W'(GOFF_VER): prdata = VERSION;
          default:           prdata = '0;
        endcase
      end
    end
  end

endmodule

// File: tb/sim_apbtmr_top.sv
module sim_apbtmr_top;

  localparam logic [31:0] VER = 32'h0001_0300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  apbtmr_top #(.VERSION(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .irq_o(irq_o)
  );

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic port_chk(input logic [31:0] act, input logic [31:0] e, input string tag);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, e);
    end
  endtask

  // monitor: pops the scoreboard in every read access phase
  always begin
    @(negedge clk);
    #1;
    if (psel && penable && !pwrite) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: unexpected read, actual %h expected none", prdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (prdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, prdata, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    port_chk(32'(irq_o), 32'h0, "R8 reset irq");
    port_chk(32'(pready), 32'h1, "R11 pready");
    bus_rd(8'h04, 32'h0, "R2 reset count");

    // channel 0 periodic, load 5
    bus_wr(8'h00, 32'd5);
    bus_wr(8'h08, 32'h3);
    bus_rd(8'h04, 32'd5, "R3 start loads count");
    ticks(3);
    bus_rd(8'h04, 32'd2, "R2 decrement");
    ticks(3);
    bus_rd(8'h04, 32'd5, "R4 periodic reload");
    bus_rd(8'hA0, 32'h1, "R9 raw status");
    bus_rd(8'hA4, 32'h1, "R9 masked status");
    port_chk(32'(irq_o), 32'h1, "R8 irq ch0");
    bus_rd(8'h0C, 32'h0, "R7 clear read data");
    bus_rd(8'hA0, 32'h0, "R7 pending cleared");
    port_chk(32'(irq_o), 32'h0, "R7 irq dropped");

    // channel 1 free-running, masked, load 2
    bus_wr(8'h14, 32'd2);
    bus_wr(8'h1C, 32'h5);
    ticks(3);
    bus_rd(8'h18, 32'hFFFF_FFFF, "R5 free-run reload");
    bus_rd(8'h04, 32'd2, "R4 ch0 keeps counting");
    bus_rd(8'hA0, 32'h2, "R9 raw with mask");
    bus_rd(8'hA4, 32'h0, "R9 masked hides");
    bus_rd(8'hA0, 32'h2, "R9 read has no effect");
    port_chk(32'(irq_o), 32'h0, "R8 masked irq low");
    ticks(1);
    bus_rd(8'h18, 32'hFFFF_FFFE, "R5 counts on from max");

    // load write while enabled ignored
    bus_wr(8'h00, 32'd100);
    bus_rd(8'h00, 32'd5, "R6 load locked");
    // disable holds value (ch0 at 1)
    bus_wr(8'h08, 32'h2);
    ticks(4);
    bus_rd(8'h04, 32'd1, "R2 hold while disabled");
    bus_wr(8'h08, 32'h3);
    bus_rd(8'h04, 32'd5, "R3 re-enable reloads");
    bus_rd(8'h08, 32'h3, "R1 control readback");

    // unmask channel 1: pending survives
    bus_wr(8'h1C, 32'h1);
    port_chk(32'(irq_o), 32'h2, "R8 unmask raises irq");
    bus_rd(8'hA4, 32'h2, "R9 masked after unmask");
    bus_rd(8'h24, 32'h1, "R1 channel status");
    bus_wr(8'h1C, 32'h0);
    port_chk(32'(irq_o), 32'h0, "R8 disable drops irq");
    bus_rd(8'hA0, 32'h2, "R8 pending kept");

    // version and read-only
    bus_rd(8'hA8, VER, "R10 version");
    bus_wr(8'hA8, 32'h0);
    bus_rd(8'hA8, VER, "R10 version write ignored");
    bus_wr(8'hA0, 32'hFF);
    bus_rd(8'hA0, 32'h2, "R10 raw write ignored");

    // last channel and unmapped
    bus_wr(8'h8C, 32'd7);
    bus_rd(8'h8C, 32'd7, "R1 channel 7 load");
    bus_rd(8'hB0, 32'h0, "R11 unmapped");
    bus_rd(8'h02, 32'h0, "R11 unaligned");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual %0d reads outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule